// File: doc/BRIEF.md
# Layered EEPROM Write-Protection Controller

This block sits beside a 256-byte EEPROM array and rules on each byte-write attempt before it reaches the cells. Three protection sources feed the ruling. The first is a hardware protect pin, which guards the whole array. The second is a software flag that can be set once and never cleared. The third is a software flag that can be set and cleared. Both software flags guard only the lower half of the array. Reads pass through the same request stream and are never refused. Each accepted request produces one decision: either allow, or refuse with a not-acknowledge indication.

Requests enter on a valid/ready stream. `wr_ready` is high whenever the functional reset is released, so the block never applies back-pressure while running. The decision stream has no ready: a decision is a single-cycle pulse that the serial front end must take when it appears. Commands and the status query are plain single-cycle strobes.

The two flags stand in for non-volatile cells. Only the power-on reset `por_n` clears them. The functional reset `rst_n` clears the pipeline and the status outputs but leaves both flags untouched. The protect pin passes through a synchronizer with `SYNC_STAGES` flops whose reset value is 0, so an undriven or reset pin reads as unprotected.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: While the synchronized protect pin is 1, every write request, at any address, yields dec_allow=0 and dec_nack=1.
- R2: While the pin is 0 and both flags are 0, every write request yields dec_allow=1 and dec_nack=0.
- R3: While the pin is 0 and either flag is 1, a write whose address has bit 7 = 0 (0x00–0x7F) is refused (allow=0, nack=1), and a write whose address has bit 7 = 1 (0x80–0xFF) is allowed.
- R4: Once set, the permanent flag stays 1. Neither cmd_clr_rev nor rst_n clears it.
- R5: cmd_set_rev sets the reversible flag and cmd_clr_rev clears it. Each accepted command pulses cmd_done one cycle later. If both strobes come in the same cycle, the set wins.
- R6: A cmd_clr_rev that arrives while the permanent flag is 1 leaves the reversible flag unchanged. It pulses cmd_refused, and not cmd_done, one cycle later.
- R7: A request with wr_is_read=1 always yields allow=1 and nack=0, whatever the pin and the flags.
- R8: Each byte request is judged on its own address. A burst of 0x7E, 0x7F, 0x80, 0x81 with a flag set gives refuse, refuse, allow, allow on consecutive cycles.
- R9: por_n=0 clears both flags. rst_n=0 clears dec_valid, stat_valid, cmd_done and cmd_refused and holds wr_ready at 0, but keeps both flags.
- R10: A decision appears on the cycle after the request is accepted. Status appears on the cycle after a query. A command takes effect for requests accepted on the following cycle. A pin change is seen by requests accepted SYNC_STAGES+1 or more edges after it (with the default of 2, the third edge).
- R11: A query returns stat_perm, stat_rev, stat_lower_prot (perm OR rev) and stat_full_prot (synchronized pin).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low; clears the flags |
| rst_n | input | 1 | Functional reset, sync, active low |
| hw_wp | input | 1 | Hardware protect pin; 1 protects the whole array |
| wr_valid | input | 1 | Request valid |
| wr_ready | output | 1 | Request ready |
| wr_addr | input | 8 | Byte address of the request |
| wr_is_read | input | 1 | 1 = read request, 0 = write request |
| cmd_set_perm | input | 1 | Strobe: set the permanent flag |
| cmd_set_rev | input | 1 | Strobe: set the reversible flag |
| cmd_clr_rev | input | 1 | Strobe: clear the reversible flag |
| query | input | 1 | Strobe: status query |
| dec_valid | output | 1 | Decision pulse |
| dec_allow | output | 1 | Access allowed |
| dec_nack | output | 1 | Access refused; front end sends NACK |
| cmd_done | output | 1 | Command carried out |
| cmd_refused | output | 1 | Clear command refused |
| stat_valid | output | 1 | Status pulse |
| stat_perm | output | 1 | Permanent flag |
| stat_rev | output | 1 | Reversible flag |
| stat_lower_prot | output | 1 | Lower half protected |
| stat_full_prot | output | 1 | Whole array protected by the pin |

## Verification
Decisions, command results and status each come one edge after their strobe. The bench drives every input on a falling edge and reads the matching result on the next falling edge, one rising edge later. It reads back-to-back bursts cycle by cycle. For pin changes, the bench counts rising edges after the pin toggles. It expects the old ruling on the first two requests and the new ruling from the third, which checks the synchronizer depth.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;
  typedef struct packed {
    logic perm;
    logic rev;
  } wp_flags_t;

  typedef enum logic [1:0] {
    RULE_OPEN,
    RULE_READ,
    RULE_PIN,
    RULE_SOFT
  } wp_rule_t;
endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign pin_out = chain[STAGES-1];
endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store
  import eeprom_wp_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      rst_n,
  input  logic      set_perm,
  input  logic      set_rev,
  input  logic      clr_rev,
  output wp_flags_t flags,
  output logic      done,
  output logic      refused
);
  logic clr_block;
  assign clr_block = clr_rev && !set_rev && flags.perm;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags <= '0;
    end else begin
      if (set_perm) flags.perm <= 1'b1;
      if (set_rev)                     flags.rev <= 1'b1;
      else if (clr_rev && !flags.perm) flags.rev <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      done    <= 1'b0;
      refused <= 1'b0;
    end else if (!rst_n) begin
      done    <= 1'b0;
      refused <= 1'b0;
    end else begin
      done    <= set_perm || set_rev || (clr_rev && !clr_block);
      refused <= clr_block;
    end
  end

  assert_perm_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
    flags.perm |=> flags.perm);
  assert_clear_refused_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (clr_rev && !set_rev && flags.perm) |=> (refused && flags.rev == $past(flags.rev)));
  assert_rev_set_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    set_rev |=> (flags.rev && done));
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              pin_prot,
  input  wp_flags_t         flags,
  output logic              dec_valid,
  output logic              dec_allow,
  output logic              dec_nack
);
  localparam int TOP_BIT = ADDR_W - 1;

  wp_rule_t rule;
  logic     lower_half;

  assign lower_half = !req_addr[TOP_BIT];

  always_comb begin
    if (req_read)                                 rule = RULE_READ;
    else if (pin_prot)                            rule = RULE_PIN;
    else if ((flags.perm || flags.rev) && lower_half) rule = RULE_SOFT;
    else                                          rule = RULE_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_allow <= 1'b0;
      dec_nack  <= 1'b0;
    end else begin
      dec_valid <= req_fire;
      dec_allow <= req_fire && (rule == RULE_OPEN || rule == RULE_READ);
      dec_nack  <= req_fire && (rule == RULE_PIN  || rule == RULE_SOFT);
    end
  end

  assert_pin_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_read && pin_prot) |=> (dec_valid && !dec_allow && dec_nack));
  assert_upper_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_read && !pin_prot && req_addr[TOP_BIT]) |=> dec_allow);
  assert_read_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_read) |=> (dec_allow && !dec_nack));
  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $onehot({dec_allow, dec_nack}));
endmodule

// File: rtl/wp_status.sv
module wp_status
  import eeprom_wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      query,
  input  wp_flags_t flags,
  input  logic      pin_prot,
  output logic      stat_valid,
  output logic      stat_perm,
  output logic      stat_rev,
  output logic      stat_lower_prot,
  output logic      stat_full_prot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid      <= 1'b0;
      stat_perm       <= 1'b0;
      stat_rev        <= 1'b0;
      stat_lower_prot <= 1'b0;
      stat_full_prot  <= 1'b0;
    end else begin
      stat_valid <= query;
      if (query) begin
        stat_perm       <= flags.perm;
        stat_rev        <= flags.rev;
        stat_lower_prot <= flags.perm || flags.rev;
        stat_full_prot  <= pin_prot;
      end
    end
  end

  assert_status_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    query |=> stat_valid);
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              hw_wp,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_is_read,
  input  logic              cmd_set_perm,
  input  logic              cmd_set_rev,
  input  logic              cmd_clr_rev,
  input  logic              query,
  output logic              dec_valid,
  output logic              dec_allow,
  output logic              dec_nack,
  output logic              cmd_done,
  output logic              cmd_refused,
  output logic              stat_valid,
  output logic              stat_perm,
  output logic              stat_rev,
  output logic              stat_lower_prot,
  output logic              stat_full_prot
);
  wp_flags_t flags;
  logic      pin_prot;
  logic      req_fire;
  logic      run;

  assign run      = rst_n && por_n;
  assign wr_ready = run;
  assign req_fire = wr_valid && wr_ready;

  wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(run), .pin_in(hw_wp), .pin_out(pin_prot)
  );

  wp_flag_store u_flags (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .set_perm(cmd_set_perm && run), .set_rev(cmd_set_rev && run),
    .clr_rev(cmd_clr_rev && run),
    .flags(flags), .done(cmd_done), .refused(cmd_refused)
  );

  wp_decide #(.ADDR_W(ADDR_W)) u_decide (
    .clk(clk), .rst_n(run), .req_fire(req_fire), .req_addr(wr_addr),
    .req_read(wr_is_read), .pin_prot(pin_prot), .flags(flags),
    .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_nack(dec_nack)
  );

  wp_status u_status (
    .clk(clk), .rst_n(run), .query(query && run), .flags(flags),
    .pin_prot(pin_prot),
    .stat_valid(stat_valid), .stat_perm(stat_perm), .stat_rev(stat_rev),
    .stat_lower_prot(stat_lower_prot), .stat_full_prot(stat_full_prot)
  );

  assert_ready_in_reset_R9: assert property (@(posedge clk)
    !rst_n |-> !wr_ready);
  assert_decision_follows_R10: assert property (@(posedge clk) disable iff (!run)
    req_fire |=> dec_valid);
endmodule

// File: tb/eeprom_wp_ctrl_test.sv
module eeprom_wp_ctrl_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, hw_wp = 1'b0;
  logic wr_valid = 1'b0, wr_is_read = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic cmd_set_perm = 1'b0, cmd_set_rev = 1'b0, cmd_clr_rev = 1'b0, query = 1'b0;
  logic wr_ready, dec_valid, dec_allow, dec_nack, cmd_done, cmd_refused;
  logic stat_valid, stat_perm, stat_rev, stat_lower_prot, stat_full_prot;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  eeprom_wp_ctrl uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic rd, input logic allow, input string req);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_is_read = rd;
    @(negedge clk); wr_valid = 1'b0; wr_is_read = 1'b0;
    chk(req, {5'd0, dec_valid, dec_allow, dec_nack}, {5'd0, 1'b1, allow, ~allow});
  endtask

  task automatic command(input int kind, input logic done_e, input logic ref_e, input string req);
    @(negedge clk);
    cmd_set_perm = (kind == 0); cmd_set_rev = (kind == 1); cmd_clr_rev = (kind == 2);
    @(negedge clk);
    cmd_set_perm = 1'b0; cmd_set_rev = 1'b0; cmd_clr_rev = 1'b0;
    chk(req, {6'd0, cmd_done, cmd_refused}, {6'd0, done_e, ref_e});
  endtask

  task automatic status(input logic p, input logic r, input logic f, input string req);
    @(negedge clk); query = 1'b1;
    @(negedge clk); query = 1'b0;
    chk(req, {3'd0, stat_valid, stat_perm, stat_rev, stat_lower_prot, stat_full_prot},
             {3'd0, 1'b1, p, r, p | r, f});
  endtask

  task automatic t_reset();
    chk("R9 ready low in reset", {7'd0, wr_ready}, 8'd0);
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset outputs", {5'd0, wr_ready, dec_valid, cmd_done}, 8'h04);
    status(1'b0, 1'b0, 1'b0, "R9 flags clear after power-on");
  endtask

  task automatic t_open();
    access(8'h00, 1'b0, 1'b1, "R2 open 00");
    access(8'h7F, 1'b0, 1'b1, "R2 open 7F");
    access(8'hFF, 1'b0, 1'b1, "R2 open FF");
  endtask

  task automatic t_pin();
    @(negedge clk); hw_wp = 1'b1;
    repeat (3) @(negedge clk);
    access(8'h00, 1'b0, 1'b0, "R1 pin blocks 00");
    access(8'hC3, 1'b0, 1'b0, "R1 pin blocks C3");
    access(8'hC3, 1'b1, 1'b1, "R7 read under pin");
    status(1'b0, 1'b0, 1'b1, "R11 full prot status");
    @(negedge clk); hw_wp = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pin_latency();
    @(negedge clk); hw_wp = 1'b1; wr_valid = 1'b1; wr_addr = 8'h90;
    @(negedge clk);
    chk("R10 pin edge1", {6'd0, dec_allow, dec_nack}, 8'h02);
    @(negedge clk);
    chk("R10 pin edge2", {6'd0, dec_allow, dec_nack}, 8'h02);
    @(negedge clk);
    chk("R10 pin edge3", {6'd0, dec_allow, dec_nack}, 8'h01);
    wr_valid = 1'b0; hw_wp = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_rev();
    command(1, 1'b1, 1'b0, "R5 set rev done");
    status(1'b0, 1'b1, 1'b0, "R5 rev status");
    access(8'h10, 1'b0, 1'b0, "R3 rev blocks 10");
    access(8'h90, 1'b0, 1'b1, "R3 rev allows 90");
    access(8'h10, 1'b1, 1'b1, "R7 read lower with rev");
    command(2, 1'b1, 1'b0, "R5 clear rev done");
    access(8'h10, 1'b0, 1'b1, "R5 lower open after clear");
  endtask

  task automatic t_cross();
    logic [7:0] addrs [4] = '{8'h7E, 8'h7F, 8'h80, 8'h81};
    logic       exp_a [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
    command(1, 1'b1, 1'b0, "R8 set rev");
    @(negedge clk); wr_valid = 1'b1; wr_addr = addrs[0];
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i < 3) wr_addr = addrs[i+1]; else wr_valid = 1'b0;
      chk("R8 burst byte", {6'd0, dec_allow, dec_nack}, {6'd0, exp_a[i], ~exp_a[i]});
    end
  endtask

  task automatic t_perm();
    command(0, 1'b1, 1'b0, "R4 set perm");
    command(2, 1'b0, 1'b1, "R6 clear refused");
    status(1'b1, 1'b1, 1'b0, "R6 rev kept");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    status(1'b1, 1'b1, 1'b0, "R4 perm survives functional reset");
    access(8'h00, 1'b0, 1'b0, "R4 lower still blocked");
  endtask

  task automatic t_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    status(1'b0, 1'b0, 1'b0, "R9 power-on clears flags");
    access(8'h00, 1'b0, 1'b1, "R9 lower open after power-on");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_open();
        t_pin();
        t_pin_latency();
        t_rev();
        t_cross();
        t_perm();
        t_por();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule